// File: doc/BRIEF.md
# SPI Master Serial Port

This block is the master side of a four-wire synchronous serial link that uses the SPI frame format. Software reaches it through a small word-addressed register port with four locations: a format register, a mode register, a status register and a data register. A write to the data register queues a word in a transmit FIFO. While the port is enabled, the shift engine takes queued words one by one and sends each one as a frame, with chip select held low for the whole frame. The word that comes back during each frame is placed in a receive FIFO, and software pops it by reading the data register.

Several settings are programmable. The word length runs from 4 to 16 bits. The serial clock is the base clock divided by 2×(rate+1). The idle level and the sampling edge of the serial clock can both be chosen. A loopback switch feeds the outgoing data straight back into the receiver. The status register reports the level of each FIFO, the not-full and not-empty conditions, a service request from a programmable threshold on each FIFO, a busy flag and a sticky receive-overrun flag. Two interrupt outputs follow the service requests when they are enabled.

Top module: `spi_port`

## Requirements
- R1: After reset the status register reads 0x0024, cs_n is high, sclk and mosi are low, and both interrupt outputs are low.
- R2: The format register (address 0) holds the size field at bits 3:0, the enable at bit 7 and the rate field at bits 15:8. The mode register (address 1) holds the receive interrupt enable at bit 0, the transmit interrupt enable at bit 1, loopback at bit 2, polarity at bit 3, phase at bit 4, the transmit threshold field at bits 9:6 and the receive threshold field at bits 13:10. Both registers read back what was written, and undefined bits read as 0.
- R3: A frame carries N bits, where N is the size field plus 1. A size field below 3 gives N = 4. Bits go out on mosi most significant first, and bits of the written word above N are ignored.
- R4: cs_n stays low for exactly (2N+3)×(rate+1) base clock cycles per frame. sclk makes exactly 2N transitions during that time.
- R5: Whenever cs_n is high, sclk rests at the polarity bit.
- R6: With phase 0, data is sampled on each transition of sclk away from its idle level. With phase 1, data is sampled on each transition back to its idle level. mosi is stable at every sampling transition.
- R7: Each frame's received word is taken from miso, or from mosi when loopback is set. It is delivered right-aligned, with the upper bits at 0.
- R8: Each FIFO holds 16 words. A write to a full transmit FIFO is dropped. Status bit 2 reports transmit not full. Status bits 11:8 and 15:12 report the transmit and receive levels modulo 16.
- R9: Status bit 3 reports receive not empty. A read of the data register (address 3) returns the oldest received word and removes it.
- R10: The transmit request (status bit 5) is high while the transmit level is at most the transmit threshold field. The receive request (status bit 6) is high while the receive level exceeds the receive threshold field. irq_tx and irq_rx are these requests ANDed with their enables.
- R11: A word that arrives while the receive FIFO is full is dropped and sets the overrun flag (status bit 7). Writing 1 to that bit of the status register (address 2) clears the flag. Writing 0 leaves it set.
- R12: Busy (status bit 4) is high while a frame is in progress or the transmit FIFO holds a word.
- R13: While the enable bit is 0, no frame starts and queued words stay in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 3) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select, low for each frame |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_tx | output | 1 | Enabled transmit service request |
| irq_rx | output | 1 | Enabled receive service request |

## Verification
The bench builds the block with the default DEPTH of 16 and DIV_W of 8, which match the 4-bit level fields and the 8-bit rate field. Every level from empty to full can then be reached, and the modulo-16 wrap of the level field shows at a full FIFO. Rate values from 0 to 3 keep frames short, so the bench can exercise both FIFOs to full and to overrun. Word lengths of 4, 8, 12 and 16 bits, plus a clamped size field, are each run under both polarities and both phases.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   localparam int WORD_W = 16;
   localparam int LVL_W  = 4;
   localparam int FLD_W  = 4;

   typedef enum logic [1:0] {
      A_FMT  = 2'd0,
      A_MODE = 2'd1,
      A_STAT = 2'd2,
      A_DATA = 2'd3
   } reg_addr_e;

   // status bit positions decoded by software
   localparam int S_TNF  = 2;
   localparam int S_RNE  = 3;
   localparam int S_BUSY = 4;
   localparam int S_TREQ = 5;
   localparam int S_RREQ = 6;
   localparam int S_OVR  = 7;

   typedef struct packed {
      logic [FLD_W-1:0] rx_thr;
      logic [FLD_W-1:0] tx_thr;
      logic             pha;
      logic             pol;
      logic             lbk;
      logic             tie;
      logic             rie;
   } mode_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
   parameter  int DEPTH = 16,
   parameter  int W     = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter  int DIV_W = 8,
   parameter  int W     = 16,
   localparam int NW    = $clog2(W + 1),
   localparam int HW    = $clog2(2 * W + 3)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [3:0]       size_m1,
   input  logic [DIV_W-1:0] rate,
   input  logic             pol,
   input  logic             pha,
   input  logic             tx_avail,
   input  logic [W-1:0]     tx_word,
   output logic             tx_take,
   input  logic             rx_bit,
   output logic             rx_put,
   output logic [W-1:0]     rx_word,
   output logic             in_frame,
   output logic             sclk,
   output logic             cs_n,
   output logic             mosi
);

   logic             active;
   logic [DIV_W-1:0] div;
   logic [HW-1:0]    half, lead, idx, last_half, data_len;
   logic [NW-1:0]    nbits;
   logic [W-1:0]     tx_sh, rx_sh;
   logic             tick, in_data, start;

   assign nbits     = (size_m1 < 4'd3) ? NW'(4) : NW'(size_m1) + 1'b1;
   assign data_len  = HW'(nbits) << 1;
   assign last_half = data_len + HW'(2);
   assign lead      = pha ? HW'(1) : HW'(2);
   assign idx       = half - lead;
   assign in_data   = (half >= lead) && (idx < data_len);
   assign tick      = (div == rate);
   assign start     = !active && en && tx_avail;

   assign tx_take  = start;
   assign rx_put   = active && en && tick && (half == last_half);
   assign rx_word  = rx_sh;
   assign in_frame = active;
   assign cs_n     = !active;
   assign mosi     = active && tx_sh[W-1];
   assign sclk     = pol ^ (active && in_data && (idx[0] ^ pha));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         div    <= '0;
         half   <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            div    <= '0;
            half   <= '0;
            tx_sh  <= tx_word << (W - int'(nbits));
            rx_sh  <= '0;
         end
      end else if (!en) begin
         active <= 1'b0;
      end else if (tick) begin
         div <= '0;
         if (half == last_half) active <= 1'b0;
         else                   half   <= half + 1'b1;
         if (in_data && !idx[0]) rx_sh <= {rx_sh[W-2:0], rx_bit};
         if (in_data && idx[0])  tx_sh <= tx_sh << 1;
      end else begin
         div <= div + 1'b1;
      end
   end

endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter  int DEPTH = 16,
   parameter  int DIV_W = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [1:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        sclk,
   output logic        cs_n,
   output logic        mosi,
   input  logic        miso,
   output logic        irq_tx,
   output logic        irq_rx
);

   generate
      if (DEPTH < 2 || DEPTH > 16) begin : g_bad_depth
         $error("spi_port: DEPTH must lie in 2..16");
      end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("spi_port: DIV_W must lie in 1..8");
      end
   endgenerate

   logic [3:0]       size_q;
   logic             en_q;
   logic [DIV_W-1:0] rate_q;
   mode_t            mode_q;
   logic             ovr_q;

   logic             wr_fmt, wr_mode, wr_stat, wr_data, rd_data;
   logic [WORD_W-1:0] tx_dout, rx_dout, rx_word;
   logic [CW-1:0]    tx_count, rx_count;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic             tx_take, rx_put, in_frame, rx_bit;
   logic             tx_req, rx_req, busy, mode_pol;
   logic [15:0]      stat_w;

   assign wr_fmt  = reg_wr && (reg_addr == A_FMT);
   assign wr_mode = reg_wr && (reg_addr == A_MODE);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign rd_data = reg_rd && (reg_addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         en_q   <= 1'b0;
         rate_q <= '0;
         mode_q <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (wr_fmt) begin
            size_q <= reg_wdata[3:0];
            en_q   <= reg_wdata[7];
            rate_q <= reg_wdata[8 +: DIV_W];
         end
         if (wr_mode) begin
            mode_q.rie    <= reg_wdata[0];
            mode_q.tie    <= reg_wdata[1];
            mode_q.lbk    <= reg_wdata[2];
            mode_q.pol    <= reg_wdata[3];
            mode_q.pha    <= reg_wdata[4];
            mode_q.tx_thr <= reg_wdata[9:6];
            mode_q.rx_thr <= reg_wdata[13:10];
         end
         if (rx_put && rx_full)             ovr_q <= 1'b1;
         else if (wr_stat && reg_wdata[S_OVR]) ovr_q <= 1'b0;
      end
   end

   spi_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_data), .din(reg_wdata),
      .pop(tx_take), .dout(tx_dout),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   spi_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_put), .din(rx_word),
      .pop(rd_data), .dout(rx_dout),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   assign rx_bit   = mode_q.lbk ? mosi : miso;
   assign mode_pol = mode_q.pol;

   spi_shift_engine #(.DIV_W(DIV_W), .W(WORD_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .en(en_q), .size_m1(size_q), .rate(rate_q),
      .pol(mode_q.pol), .pha(mode_q.pha),
      .tx_avail(!tx_empty), .tx_word(tx_dout), .tx_take(tx_take),
      .rx_bit(rx_bit), .rx_put(rx_put), .rx_word(rx_word),
      .in_frame(in_frame),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
   );

   assign tx_req = int'(tx_count) <= int'(mode_q.tx_thr);
   assign rx_req = int'(rx_count) >  int'(mode_q.rx_thr);
   assign busy   = in_frame || !tx_empty;
   assign irq_tx = mode_q.tie && tx_req;
   assign irq_rx = mode_q.rie && rx_req;

   always_comb begin
      stat_w           = '0;
      stat_w[S_TNF]    = !tx_full;
      stat_w[S_RNE]    = !rx_empty;
      stat_w[S_BUSY]   = busy;
      stat_w[S_TREQ]   = tx_req;
      stat_w[S_RREQ]   = rx_req;
      stat_w[S_OVR]    = ovr_q;
      stat_w[11:8]     = LVL_W'(tx_count);
      stat_w[15:12]    = LVL_W'(rx_count);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_FMT: begin
            reg_rdata[3:0]        = size_q;
            reg_rdata[7]          = en_q;
            reg_rdata[8 +: DIV_W] = rate_q;
         end
         A_MODE: begin
            reg_rdata[0]     = mode_q.rie;
            reg_rdata[1]     = mode_q.tie;
            reg_rdata[2]     = mode_q.lbk;
            reg_rdata[3]     = mode_q.pol;
            reg_rdata[4]     = mode_q.pha;
            reg_rdata[9:6]   = mode_q.tx_thr;
            reg_rdata[13:10] = mode_q.rx_thr;
         end
         A_STAT:  reg_rdata = stat_w;
         default: reg_rdata = rx_dout;
      endcase
   end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
   parameter  int DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          sclk,
   input logic          mode_pol,
   input logic          busy,
   input logic [CW-1:0] tx_count,
   input logic [CW-1:0] rx_count,
   input logic          rx_put,
   input logic          rx_full,
   input logic          rx_empty,
   input logic          ovr_q,
   input logic          irq_rx
);

   assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk == mode_pol));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

   assert_ovr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(rx_put && rx_full));

   assert_busy_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> !rx_empty);

endmodule

bind spi_port spi_port_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
   .mode_pol(mode_pol), .busy(busy),
   .tx_count(tx_count), .rx_count(rx_count),
   .rx_put(rx_put), .rx_full(rx_full), .rx_empty(rx_empty),
   .ovr_q(ovr_q), .irq_rx(irq_rx)
);

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sclk, cs_n, mosi, miso, irq_tx, irq_rx;

   int n_chk = 0, n_fail = 0;
   logic pol_cfg = 1'b0, pha_cfg = 1'b0;
   logic [15:0] cap = '0;
   int edges = 0, run_len = 0, last_len = 0;

   always #10 clk = ~clk;

   assign miso = ~mosi;  // external path inverts, loopback does not

   spi_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   // frame observers
   always @(negedge cs_n) begin
      cap   = '0;
      edges = 0;
   end
   always @(sclk) begin
      if (!cs_n) begin
         edges = edges + 1;
         if (sclk == (pha_cfg ? pol_cfg : !pol_cfg)) cap = {cap[14:0], mosi};
      end
   end
   always @(negedge clk) begin
      if (!cs_n) run_len = run_len + 1;
      else if (run_len != 0) begin
         last_len = run_len;
         run_len  = 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #2 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 cs_n", int'(cs_n), 1);
      chk("R1 sclk", int'(sclk), 0);
      chk("R1 mosi", int'(mosi), 0);
      chk("R1 irqs", int'({irq_tx, irq_rx}), 0);
      rd(2'd2, d);
      chk("R1 status", int'(d), 16'h0024);
   endtask

   task automatic t_regs();
      logic [15:0] d;
      wr(2'd0, 16'h0507);
      rd(2'd0, d);
      chk("R2 format readback", int'(d), 16'h0507);
      wr(2'd1, 16'hFFFF);
      rd(2'd1, d);
      chk("R2 mode readback", int'(d), 16'h3FDF);
      wr(2'd1, 16'h0000);
   endtask

   task automatic t_frame(input int size, input int rate, input logic pol,
                          input logic pha, input logic lbk, input logic [15:0] word);
      logic [15:0] d, mask;
      int n;
      n    = (size < 3) ? 4 : size + 1;
      mask = 16'((32'd1 << n) - 1);
      pol_cfg = pol; pha_cfg = pha;
      wr(2'd1, {11'd0, pha, pol, lbk, 2'b00});
      wr(2'd0, 16'((rate << 8) | 16'h80 | size));
      chk("R5 idle level before frame", int'(sclk), int'(pol));
      wr(2'd3, word);
      @(negedge cs_n);
      rd(2'd2, d);
      chk("R12 busy in frame", int'(d[4]), 1);
      @(posedge cs_n);
      repeat (2) @(negedge clk);
      chk("R4 cs_n low cycles", last_len, (2 * n + 3) * (rate + 1));
      chk("R4 sclk transitions", edges, 2 * n);
      chk("R3 R6 bits at sampling edges", int'(cap & mask), int'(word & mask));
      chk("R5 idle level after frame", int'(sclk), int'(pol));
      rd(2'd2, d);
      chk("R9 rx not empty", int'(d[3]), 1);
      chk("R12 busy cleared", int'(d[4]), 0);
      rd(2'd3, d);
      chk("R7 received word", int'(d), int'(lbk ? (word & mask) : (~word & mask)));
      rd(2'd2, d);
      chk("R9 rx empty after pop", int'(d[3]), 0);
   endtask

   task automatic t_fifo();
      logic [15:0] d;
      wr(2'd0, 16'h0003);
      wr(2'd1, 16'h04C3);       // tx threshold field 3, rx field 1, both irqs on
      pol_cfg = 1'b0; pha_cfg = 1'b0;
      chk("R10 tx request when empty", int'(irq_tx), 1);
      for (int k = 0; k < 16; k++) begin
         wr(2'd3, 16'((k * 7 + 3) & 15));
         if (k == 2) chk("R10 tx request at level 3", int'(irq_tx), 1);
         if (k == 3) chk("R10 tx request at level 4", int'(irq_tx), 0);
      end
      rd(2'd2, d);
      chk("R8 R12 full tx status", int'(d), 16'h0010);
      wr(2'd3, 16'h000F);       // dropped: tx queue full
      chk("R13 no frame while disabled", int'(cs_n), 1);
      rd(2'd2, d);
      chk("R8 R13 status after extra write", int'(d), 16'h0010);
      wr(2'd1, 16'h04C7);
      wr(2'd0, 16'h0083);
      repeat (16) @(posedge cs_n);
      repeat (2) @(negedge clk);
      rd(2'd2, d);
      chk("R8 R10 full rx status", int'(d), 16'h006C);
      chk("R10 rx irq", int'(irq_rx), 1);
      for (int i = 0; i < 16; i++) begin
         rd(2'd3, d);
         chk("R9 R8 fifo order", int'(d), (i * 7 + 3) & 15);
         if (i == 13) chk("R10 rx request at level 2", int'(irq_rx), 1);
         if (i == 14) chk("R10 rx request at level 1", int'(irq_rx), 0);
      end
   endtask

   task automatic t_overrun();
      logic [15:0] d;
      wr(2'd0, 16'h0003);
      wr(2'd1, 16'h0004);
      for (int k = 0; k < 16; k++) wr(2'd3, 16'((k * 5 + 2) & 15));
      wr(2'd0, 16'h0083);
      repeat (16) @(posedge cs_n);
      wr(2'd3, 16'h000A);
      @(posedge cs_n);
      repeat (2) @(negedge clk);
      rd(2'd2, d);
      chk("R11 overrun set", int'(d), 16'h00EC);
      wr(2'd2, 16'h0000);
      rd(2'd2, d);
      chk("R11 write 0 keeps flag", int'(d[7]), 1);
      wr(2'd2, 16'h0080);
      rd(2'd2, d);
      chk("R11 write 1 clears flag", int'(d[7]), 0);
      for (int i = 0; i < 16; i++) begin
         rd(2'd3, d);
         if (i == 0)  chk("R11 oldest kept", int'(d), 2);
         if (i == 15) chk("R11 late word dropped", int'(d), (15 * 5 + 2) & 15);
      end
      rd(2'd2, d);
      chk("R11 rx empty after drain", int'(d[3]), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_frame(7, 0, 1'b0, 1'b0, 1'b1, 16'h00A5);
      t_frame(15, 2, 1'b1, 1'b1, 1'b0, 16'hC3F1);
      t_frame(3, 1, 1'b0, 1'b1, 1'b1, 16'h0009);
      t_frame(1, 0, 1'b1, 1'b0, 1'b0, 16'h0F6);   // R3 clamp to 4 bits
      t_frame(11, 3, 1'b1, 1'b0, 1'b1, 16'h35A3);
      t_frame(15, 0, 1'b0, 1'b1, 1'b1, 16'h8001);
      t_fifo();
      t_overrun();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule